// File: doc/BRIEF.md
# Prioritized Interrupt Vector With Access Clear

This block collects the six event flags of a real-time clock and turns them into one interrupt request and a vector value. Each source raises its flag with a single-cycle set pulse. A flag stays pending until it is cleared. The flags, listed from highest to lowest priority, are: oscillator fault (bit 0), alarm (bit 1), interval event (bit 2), ready (bit 3), prescaler 0 tick (bit 4) and prescaler 1 tick (bit 5).

Each flag has its own enable bit. A disabled flag still latches, but it does not drive the request and it does not take part in forming the vector. The vector names the highest-priority flag that is both pending and enabled. It is an even number, so software can add it to a program counter to jump into a branch table.

Any access to the vector register, read or write, is signalled by one strobe. The access clears exactly the flag that the vector shows in that same cycle, so the value returned names the flag being cleared. A separate mask lets software clear any set of flags directly.

Top module: `rtc_irq_vector`

## Requirements
- R1: After reset all flags are clear, `irq_o` is 0 and `vec_o` is 0.
- R2: A set pulse on `evt_set_i[i]` makes flag i pending from the next clock edge. The flag stays pending until it is cleared.
- R3: `vec_o` is 0 when no flag is both pending and enabled. Otherwise it equals 2*(i+1), where i is the lowest-numbered pending enabled bit: bit 0 oscillator fault gives 2, bit 1 alarm gives 4, bit 2 interval gives 6, bit 3 ready gives 8, bit 4 prescaler 0 gives 10, bit 5 prescaler 1 gives 12.
- R4: A flag whose `evt_en_i` bit is 0 has no effect on `vec_o` or `irq_o`. It stays pending, and it shows up as soon as its enable bit is set.
- R5: When `vec_acc_i` is high, the flag shown on `vec_o` in that cycle is cleared at the clock edge. No other flag changes.
- R6: `irq_o` is 1 exactly when some flag is both pending and enabled. If another enabled flag is still pending after a vector access, `irq_o` stays high and `vec_o` moves to that flag.
- R7: Each bit set in `sw_clr_i` clears the matching flag at the clock edge, whether or not that flag is enabled.
- R8: If a set pulse and a clear (from software or from a vector access) hit the same flag in the same cycle, the flag ends up pending.
- R9: A vector access while nothing enabled is pending clears no flag. This includes flags that are pending but disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_i | input | 6 | Single-cycle set pulse per source, bit 0 has the highest priority |
| evt_en_i | input | 6 | Enable bit per source |
| sw_clr_i | input | 6 | Software clear mask, one bit per flag |
| vec_acc_i | input | 1 | Vector register access strobe (read or write) |
| irq_o | output | 1 | Combined interrupt request |
| vec_o | output | 4 | Vector of the highest-priority pending enabled flag |

## Verification
The bench drains a full set of six flags through repeated vector accesses. A design that cleared more than one flag per access, or cleared them in the wrong order, would skip vector values or drop the request early. It parks pending flags behind a zero enable and then accesses the vector, which catches a design that clears or reports a disabled flag. It also aims a set pulse at the same flag that a software clear or a vector access removes in that cycle, where a design that let the clear win would lose an event.

// File: rtl/rtc_irq_vector.sv
module rtc_irq_vector #(
  parameter int N_SRC = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_SRC-1:0]                  evt_set_i,
  input  logic [N_SRC-1:0]                  evt_en_i,
  input  logic [N_SRC-1:0]                  sw_clr_i,
  input  logic                              vec_acc_i,
  output logic                              irq_o,
  output logic [$clog2(2*N_SRC+1)-1:0]      vec_o
);
  localparam int VW = $clog2(2*N_SRC+1);

  logic [N_SRC-1:0] flags_q;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] top_mask;
  logic [VW-1:0]    vec_d;

  assign pend  = flags_q & evt_en_i;
  assign irq_o = |pend;

  always_comb begin
    top_mask = '0;
    vec_d    = '0;
    for (int i = N_SRC-1; i >= 0; i--) begin
      if (pend[i]) begin
        top_mask    = '0;
        top_mask[i] = 1'b1;
        vec_d       = VW'(2*(i+1));
      end
    end
  end

  assign vec_o = vec_d;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~(sw_clr_i | (vec_acc_i ? top_mask : '0))) | evt_set_i;
  end
endmodule

module rtc_irq_vector_chk #(
  parameter int N_SRC = 6,
  parameter int VW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt_set_i,
  input logic [N_SRC-1:0] evt_en_i,
  input logic [N_SRC-1:0] sw_clr_i,
  input logic             vec_acc_i,
  input logic             irq_o,
  input logic [VW-1:0]    vec_o,
  input logic [N_SRC-1:0] flags
);
  logic [VW-1:0]    shown_idx;
  logic [N_SRC-1:0] shown_mask;
  assign shown_idx  = (vec_o >> 1) - VW'(1);
  assign shown_mask = (vec_o == '0) ? '0 : ({{(N_SRC-1){1'b0}}, 1'b1} << shown_idx);

  // R6
  irq_matches_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(flags & evt_en_i)));

  // R3
  no_higher_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o != '0) |-> ((flags & evt_en_i & (shown_mask - N_SRC'(1))) == '0));

  // R4
  shown_is_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shown_mask & ~(flags & evt_en_i)) == '0);

  // R5
  access_clears_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_acc_i && ((shown_mask & ~evt_set_i) != '0)) |=> ((flags & $past(shown_mask)) == '0));

  // R5
  access_spares_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_acc_i && sw_clr_i == '0) |=> ((flags & ~$past(shown_mask)) == ($past(flags) & ~$past(shown_mask))) || ($past(evt_set_i) != '0));

  // R7
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_clr_i & ~evt_set_i) != '0) |=> ((flags & $past(sw_clr_i & ~evt_set_i)) == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set_i != '0) |=> ((flags & $past(evt_set_i)) == $past(evt_set_i)));
endmodule

bind rtc_irq_vector rtc_irq_vector_chk #(.N_SRC(N_SRC), .VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set_i), .evt_en_i(evt_en_i),
  .sw_clr_i(sw_clr_i), .vec_acc_i(vec_acc_i), .irq_o(irq_o), .vec_o(vec_o),
  .flags(flags_q)
);

// File: tb/rtc_irq_vector_tb_top.sv
module rtc_irq_vector_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] evt_set_i = '0;
  logic [5:0] evt_en_i = '0;
  logic [5:0] sw_clr_i = '0;
  logic       vec_acc_i = 1'b0;
  logic       irq_o;
  logic [3:0] vec_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] model = '0;
  logic [3:0] exp_vec_q[$];
  logic       exp_irq_q[$];
  string      exp_tag_q[$];
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_irq_vector dut_i (
    .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set_i), .evt_en_i(evt_en_i),
    .sw_clr_i(sw_clr_i), .vec_acc_i(vec_acc_i), .irq_o(irq_o), .vec_o(vec_o)
  );

  function automatic logic [5:0] top_of(input logic [5:0] p);
    top_of = '0;
    for (int i = 5; i >= 0; i--) if (p[i]) begin top_of = '0; top_of[i] = 1'b1; end
  endfunction

  function automatic logic [3:0] vec_of(input logic [5:0] p);
    vec_of = '0;
    for (int i = 5; i >= 0; i--) if (p[i]) vec_of = 4'(2*(i+1));
  endfunction

  task automatic step(input logic [5:0] s, input logic [5:0] e, input logic [5:0] c,
                      input logic a, input string tag);
    logic [5:0] p;
    @(negedge clk);
    evt_set_i = s; evt_en_i = e; sw_clr_i = c; vec_acc_i = a;
    p = model & e;
    exp_vec_q.push_back(vec_of(p));
    exp_irq_q.push_back(|p);
    exp_tag_q.push_back(tag);
    model = (model & ~(c | (a ? top_of(p) : 6'h00))) | s;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (exp_vec_q.size() != 0) begin
        logic [3:0] ev;
        logic       ei;
        string      t;
        ev = exp_vec_q.pop_front();
        ei = exp_irq_q.pop_front();
        t  = exp_tag_q.pop_front();
        checks++;
        if (vec_o !== ev || irq_o !== ei) begin
          errors++;
          $display("FAIL %s: vec=%0d irq=%0b expected vec=%0d irq=%0b", t, vec_o, irq_o, ev, ei);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(6'h00, 6'h3F, 6'h00, 1'b0, "R1 reset state");
    step(6'h3F, 6'h3F, 6'h00, 1'b0, "R2 set all");
    step(6'h00, 6'h3F, 6'h00, 1'b0, "R3 oscillator fault first");
    for (int k = 0; k < 6; k++) step(6'h00, 6'h3F, 6'h00, 1'b1, "R5 R6 drain by access");
    step(6'h00, 6'h3F, 6'h00, 1'b0, "R6 all drained");
    step(6'h14, 6'h3F, 6'h00, 1'b0, "R2 set interval and ps0");
    step(6'h00, 6'h3F, 6'h00, 1'b0, "R3 interval over ps0");
    step(6'h00, 6'h3F, 6'h3F, 1'b0, "R7 clear all");
    step(6'h01, 6'h3E, 6'h00, 1'b0, "R4 set disabled fault");
    step(6'h00, 6'h3E, 6'h00, 1'b0, "R4 disabled fault hidden");
    step(6'h20, 6'h3E, 6'h00, 1'b0, "R4 set ps1");
    step(6'h00, 6'h3E, 6'h00, 1'b1, "R4 R5 access shows ps1 only");
    step(6'h00, 6'h3E, 6'h00, 1'b0, "R5 ps1 cleared fault kept");
    step(6'h00, 6'h3F, 6'h00, 1'b0, "R4 fault appears when enabled");
    step(6'h00, 6'h00, 6'h01, 1'b0, "R7 clear while disabled");
    step(6'h00, 6'h3F, 6'h00, 1'b0, "R7 fault gone");
    step(6'h08, 6'h3F, 6'h08, 1'b0, "R8 set with sw clear");
    step(6'h00, 6'h3F, 6'h00, 1'b0, "R8 ready kept");
    step(6'h08, 6'h3F, 6'h00, 1'b1, "R8 set with access");
    step(6'h00, 6'h3F, 6'h00, 1'b0, "R8 ready still pending");
    step(6'h02, 6'h00, 6'h08, 1'b0, "R2 alarm while disabled");
    step(6'h00, 6'h00, 6'h00, 1'b1, "R9 access nothing enabled");
    step(6'h00, 6'h3F, 6'h00, 1'b0, "R9 alarm survived");
    step(6'h10, 6'h3F, 6'h00, 1'b1, "R5 access alarm while ps0 set");
    step(6'h00, 6'h3F, 6'h00, 1'b0, "R6 ps0 follows");
    step(6'h00, 6'h2F, 6'h00, 1'b0, "R4 ps0 masked");
    step(6'h00, 6'h3F, 6'h00, 1'b1, "R5 access ps0");
    step(6'h00, 6'h3F, 6'h00, 1'b0, "R1 idle again");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule